// File: doc/BRIEF.md
# Integer Result Status Update Unit

This block runs one 32-bit integer operation per clock and updates the architectural status that follows it: the carry, overflow and sticky summary-overflow flags of the fixed-point exception state, and the leading 4-bit field of a 32-bit condition register. The supported operations are add, add-extended (the current carry flag is a third addend), and, or, xor and not. Each instruction carries three enables. Carry-record lets the carry flag be replaced. Overflow-enable lets the overflow and summary-overflow flags be updated. Record lets condition field 0 be rewritten from a signed compare of the result against zero.

The sum is formed one bit wider than the operands in two views. A zero-extended view gives the carry out. A sign-extended view gives the overflow, as a mismatch between its two top bits. The logical operations derive both views from the result alone, so their carry and overflow are always zero.

An input beat is taken on `valid_i`. The result and all flags appear registered one clock later with `valid_o`. Between beats, all state holds.

Top module: `int_status_unit`

## Requirements
- R1: While `rst_ni` is low and after its release, `valid_o` is 0, `result_o` is 0, `so_o`/`ov_o`/`ca_o` are 0 and `cr_o` is 0.
- R2: `valid_o` is high in exactly the cycle after a cycle with `valid_i` high. Without `valid_i`, `result_o`, the flags and `cr_o` keep their values.
- R3: The operation codes on `op_i` are 0 add, 1 add-extended, 2 and, 3 or, 4 xor, 5 not (of A), and 6/7 pass A through. For add, the result is (A+B) mod 2^32 and the computed carry is bit 32 of the zero-extended sum.
- R4: With `ov_en_i` set and a signed overflow (bits 32 and 31 of the sign-extended sum differ), both `ov_o` and `so_o` become 1.
- R5: With `ov_en_i` set and no overflow, `ov_o` becomes 0 and `so_o` keeps its value. `so_o` is cleared only by reset.
- R6: With `carry_rec_i` set, `ca_o` takes the computed carry. With it clear, `ca_o` is unchanged. With `ov_en_i` clear, `ov_o` and `so_o` are unchanged.
- R7: Add-extended adds the current `ca_o` to A+B, for both the result and the carry and overflow computation.
- R8: For codes 2 to 7, the result is the logical function, and the computed carry and overflow are 0.
- R9: With `rec_i` set, `cr_o[31:28]` becomes {LT, GT, EQ, SO}. Exactly one of LT/GT/EQ is set, from the signed result compared with zero. SO is the `so_o` value after this operation's update.
- R10: With `rec_i` clear, `cr_o` is unchanged. `cr_o[27:0]` never changes after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation beat valid |
| op_i | input | 3 | Operation select |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| carry_rec_i | input | 1 | Record the carry flag |
| ov_en_i | input | 1 | Update the overflow and summary-overflow flags |
| rec_i | input | 1 | Record condition field 0 |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 32 | Registered result |
| so_o | output | 1 | Sticky summary overflow |
| ov_o | output | 1 | Overflow |
| ca_o | output | 1 | Carry |
| cr_o | output | 32 | Condition register |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path and a 32-bit condition register holding eight 4-bit fields. At that width the carry and overflow boundaries sit at bit 32 and bit 31. Directed operands such as 0xFFFFFFFF+1, 0x7FFFFFFF+1 and 0x80000000+0x80000000 reach those boundaries exactly. Field 0 is the top nibble, so an unintended write into the lower 28 bits is visible at once. A long random run with a mix of enables then drives the sticky summary flag and the carry chain of add-extended through many sequences, and a behavioural model checks every clock.

// File: rtl/isu_pkg.sv
package isu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDE = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_NOT  = 3'd5,
    OP_PASA = 3'd6,
    OP_PASB = 3'd7
  } op_e;

  typedef struct packed {
    logic so;
    logic ov;
    logic ca;
  } xer_t;

  localparam int unsigned FIELD_W = 4;
endpackage

// File: rtl/isu_alu.sv
module isu_alu
  import isu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic              cin_add;
  logic [DATA_W:0]   u_sum, s_sum, zx_view, sx_view;
  logic              is_arith;

  assign cin_add  = (op_i == OP_ADDE) ? cin_i : 1'b0;
  assign is_arith = (op_i == OP_ADD) || (op_i == OP_ADDE);
  assign u_sum = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_add};
  assign s_sum = {a_i[MSB], a_i} + {b_i[MSB], b_i} + {{DATA_W{1'b0}}, cin_add};

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_ADDE: res_o = u_sum[MSB:0];
      OP_AND:          res_o = a_i & b_i;
      OP_OR:           res_o = a_i | b_i;
      OP_XOR:          res_o = a_i ^ b_i;
      OP_NOT:          res_o = ~a_i;
      default:         res_o = a_i;
    endcase
  end

  // logical ops: views come from the result only, no propagation
  assign zx_view = {1'b0, res_o};
  assign sx_view = {res_o[MSB], res_o};

  assign carry_o = is_arith ? u_sum[DATA_W] : zx_view[DATA_W];
  assign ovf_o   = is_arith ? (s_sum[DATA_W] ^ s_sum[MSB])
                            : (sx_view[DATA_W] ^ sx_view[MSB]);
endmodule

// File: rtl/isu_xer_upd.sv
module isu_xer_upd
  import isu_pkg::*;
(
  input  xer_t cur_i,
  input  logic carry_i,
  input  logic ovf_i,
  input  logic carry_rec_i,
  input  logic ov_en_i,
  output xer_t nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (ov_en_i) begin
      nxt_o.ov = ovf_i;
      if (ovf_i) nxt_o.so = 1'b1;
    end
    if (carry_rec_i) nxt_o.ca = carry_i;
  end
endmodule

// File: rtl/isu_cr_upd.sv
module isu_cr_upd
  import isu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CR_W   = 32
) (
  input  logic [CR_W-1:0]   cr_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              so_i,
  input  logic              rec_i,
  output logic [CR_W-1:0]   cr_o
);
  localparam int unsigned TOP = CR_W - 1;

  logic lt, gt, eq;
  logic [FIELD_W-1:0] fld;

  assign lt  = res_i[DATA_W-1];
  assign eq  = (res_i == '0);
  assign gt  = !lt && !eq;
  assign fld = {lt, gt, eq, so_i};

  always_comb begin
    cr_o = cr_i;
    if (rec_i) cr_o[TOP -: FIELD_W] = fld;
  end
endmodule

// File: rtl/int_status_unit.sv
module int_status_unit
  import isu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CR_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_rec_i,
  input  logic              ov_en_i,
  input  logic              rec_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              so_o,
  output logic              ov_o,
  output logic              ca_o,
  output logic [CR_W-1:0]   cr_o
);
  localparam int unsigned LOW_W = CR_W - FIELD_W;

  xer_t              xer_q, xer_d;
  logic [CR_W-1:0]   cr_q, cr_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              vld_q, carry, ovf;

  isu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (op_e'(op_i)),
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (xer_q.ca),
    .res_o  (res_d),
    .carry_o(carry),
    .ovf_o  (ovf)
  );

  isu_xer_upd u_xer (
    .cur_i      (xer_q),
    .carry_i    (carry),
    .ovf_i      (ovf),
    .carry_rec_i(carry_rec_i),
    .ov_en_i    (ov_en_i),
    .nxt_o      (xer_d)
  );

  isu_cr_upd #(.DATA_W(DATA_W), .CR_W(CR_W)) u_cr (
    .cr_i (cr_q),
    .res_i(res_d),
    .so_i (xer_d.so),
    .rec_i(rec_i),
    .cr_o (cr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
      xer_q <= '0;
      cr_q  <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        res_q <= res_d;
        xer_q <= xer_d;
        cr_q  <= cr_d;
      end
    end
  end

  assign valid_o  = vld_q;
  assign result_o = res_q;
  assign so_o     = xer_q.so;
  assign ov_o     = xer_q.ov;
  assign ca_o     = xer_q.ca;
  assign cr_o     = cr_q;

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(cr_o) && !valid_o));
  // R5
  so_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_o |=> so_o);
  // R4
  ov_implies_so_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_o |-> so_o);
  // R6
  carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_rec_i |=> $stable(ca_o));
  // R6
  ov_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ov_en_i |=> ($stable(ov_o) && $stable(so_o)));
  // R9
  cr0_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rec_i) |=> ($countones(cr_o[CR_W-1 -: 3]) == 1));
  // R9
  cr0_so_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rec_i) |=> (cr_o[LOW_W] == so_o));
  // R10
  cr_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cr_o[LOW_W-1:0]));
  // R8
  logic_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 3'd2 && carry_rec_i) |=> !ca_o);
endmodule

// File: tb/sim_int_status_unit.sv
`timescale 1ns/1ps
module sim_int_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] a = '0, b = '0;
  logic        crec = 1'b0, oen = 1'b0, rec = 1'b0;
  logic        valid_o, so_o, ov_o, ca_o;
  logic [31:0] result_o, cr_o;

  int checks = 0;
  int fails  = 0;

  logic        m_valid = 1'b0;
  logic [31:0] m_res = '0, m_cr = '0;
  logic        m_so = 1'b0, m_ov = 1'b0, m_ca = 1'b0;

  always #2.5 clk = ~clk;

  int_status_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
    .carry_rec_i(crec), .ov_en_i(oen), .rec_i(rec), .valid_o(valid_o),
    .result_o(result_o), .so_o(so_o), .ov_o(ov_o), .ca_o(ca_o), .cr_o(cr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " valid (R2)"}, {31'b0, valid_o}, {31'b0, m_valid});
    chk({tag, " result"}, result_o, m_res);
    chk({tag, " so"}, {31'b0, so_o}, {31'b0, m_so});
    chk({tag, " ov"}, {31'b0, ov_o}, {31'b0, m_ov});
    chk({tag, " ca"}, {31'b0, ca_o}, {31'b0, m_ca});
    chk({tag, " cr"}, cr_o, m_cr);
  endtask

  // behavioural reference model: one beat
  task automatic model(input logic v, input logic [2:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic cr_en, input logic ov_en,
                       input logic r_en);
    longint unsigned us;
    longint          ss;
    logic [31:0]     r;
    logic            c, ovf, cin;
    m_valid = v;
    if (!v) return;
    cin = (o == 3'd1) ? m_ca : 1'b0;
    us  = longint'(x) + longint'(y) + longint'(cin);
    ss  = longint'($signed(x)) + longint'($signed(y)) + longint'(cin);
    c = 1'b0; ovf = 1'b0;
    case (o)
      3'd0, 3'd1: begin r = us[31:0]; c = us[32]; ovf = ss[32] != ss[31]; end
      3'd2: r = x & y;
      3'd3: r = x | y;
      3'd4: r = x ^ y;
      3'd5: r = ~x;
      default: r = x;
    endcase
    m_res = r;
    if (ov_en) begin
      m_ov = ovf;
      if (ovf) m_so = 1'b1;
    end
    if (cr_en) m_ca = c;
    if (r_en) begin
      if ($signed(r) < 0)      m_cr[31:28] = {3'b100, m_so};
      else if ($signed(r) > 0) m_cr[31:28] = {3'b010, m_so};
      else                     m_cr[31:28] = {3'b001, m_so};
    end
  endtask

  task automatic beat(input string tag, input logic v, input logic [2:0] o,
                      input logic [31:0] x, input logic [31:0] y,
                      input logic cr_en, input logic ov_en, input logic r_en);
    @(negedge clk);
    valid = v; op = o; a = x; b = y; crec = cr_en; oen = ov_en; rec = r_en;
    model(v, o, x, y, cr_en, ov_en, r_en);
    @(negedge clk);
    valid = 1'b0;
    compare_all(tag);
    m_valid = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after reset");

    beat("R3 add small",            1, 3'd0, 32'd1,          32'd2,          1, 0, 0);
    beat("R3 add carry out",        1, 3'd0, 32'hFFFF_FFFF,  32'd1,          1, 0, 0);
    beat("R6 carry hold",           1, 3'd0, 32'd5,          32'd6,          0, 0, 0);
    beat("R7 adde with ca",         1, 3'd1, 32'd10,         32'd20,         1, 0, 0);
    beat("R6 ov disabled",          1, 3'd0, 32'h7FFF_FFFF,  32'd1,          0, 0, 0);
    beat("R4 overflow set",         1, 3'd0, 32'h7FFF_FFFF,  32'd1,          0, 1, 1);
    beat("R5 ov clear so sticky",   1, 3'd0, 32'd3,          32'd4,          0, 1, 1);
    beat("R4 neg overflow carry",   1, 3'd0, 32'h8000_0000,  32'h8000_0000,  1, 1, 0);
    beat("R7 adde carry in",        1, 3'd1, 32'hFFFF_FFFF,  32'd0,          1, 1, 1);
    beat("R8 and",                  1, 3'd2, 32'hF0F0_1234,  32'h0FF0_FFFF,  1, 1, 0);
    beat("R8 or",                   1, 3'd3, 32'h8000_0000,  32'h0000_0001,  1, 0, 1);
    beat("R8 xor",                  1, 3'd4, 32'hAAAA_5555,  32'hAAAA_5555,  0, 0, 1);
    beat("R8 not",                  1, 3'd5, 32'h0000_0000,  32'd0,          1, 1, 1);
    beat("R8 pass",                 1, 3'd6, 32'h0000_0042,  32'hDEAD_BEEF,  1, 0, 1);
    beat("R9 zero",                 1, 3'd0, 32'hFFFF_FFFF,  32'd1,          0, 0, 1);
    beat("R10 rec clear",           1, 3'd0, 32'hFFFF_FFFE,  32'd0,          0, 0, 0);
    beat("R2 idle hold",            0, 3'd0, 32'h1234_5678,  32'd9,          1, 1, 1);

    // R1 second reset clears sticky state
    @(negedge clk);
    rst_n = 1'b0;
    m_res = '0; m_so = 0; m_ov = 0; m_ca = 0; m_cr = '0; m_valid = 0;
    @(negedge clk);
    compare_all("R1 re-reset");
    rst_n = 1'b1;

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom;
      if (i % 7 == 0) x = 32'h7FFF_FFFF;
      if (i % 11 == 0) y = 32'hFFFF_FFFF;
      beat("R3 R9 random", ($urandom % 5) != 0, 3'($urandom), x, y,
           1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule